// File: doc/BRIEF.md
# DMA Access Fault Capture Unit

This unit sits next to a DMA engine and judges each transfer before it runs. Each cycle the engine may present the outcome of a memory-permission check, together with the current DMA address and the transfer direction. An allowed outcome produces a one-cycle access-ok pulse and touches nothing else. A denied outcome is turned into three 16-bit status words that the CPU can read: a general status word that encodes the fault class, the transfer direction and the parity-interrupt setting; a high bus-status word that carries a fixed tag and the upper address bits; and a low bus-status word that carries the lower 16 address bits.

A denied access can also raise a level-7 interrupt request toward the CPU. This happens only when the error-interrupt enable is set. The captured words and the interrupt stay latched until the CPU pulses a clear strobe. A later fault replaces the captured words. A small two-state controller (Clean, Held) decides when to load and when to wipe the capture registers.

Controller states and transitions:
- Clean goes to Held on a denied check.
- Held stays in Held on a denied check, which overwrites the captured words.
- Held goes back to Clean on a clear strobe with no denied check in the same cycle.
- Clean stays in Clean otherwise.

Top module: `dma_fault_capture`

## Requirements
- R1: During and after reset, all three status words read 0x0000, and both access-ok and the interrupt request are low.
- R2: A check with code 0 (allowed) raises access-ok in the next cycle for exactly one cycle. It leaves all three status words and the interrupt request unchanged.
- R3: A check with code 1 (page not present) loads the general status word with 0xABFF as its base value.
- R4: A check with code 2 (user access above the 4 MB limit) loads the general status word with 0xBAFF as its base value.
- R5: A check with code 3 (kernel-only or write-protected page) loads the general status word with 0xBBFF as its base value.
- R6: On any fault, bit 14 (0x4000) of the general status word is set when the transfer is a read (direction input high).
- R7: On any fault, bit 10 (0x0400) of the general status word is set when the parity-interrupt enable is high.
- R8: On any fault, the high bus-status word becomes 0x3C00 ORed with DMA address bits 21:16 placed in bits 5:0. The low bus-status word becomes DMA address bits 15:0.
- R9: A fault sets the level-7 interrupt request in the next cycle only when the error-interrupt enable is high. Once set, the request stays high until it is cleared.
- R10: A clear strobe with no fault in the same cycle sets all three words to 0x0000 and drops the interrupt request. If a fault arrives in the same cycle as the clear, the new fault is captured, and the interrupt request then follows only that fault's enable.
- R11: A fault that arrives while an earlier one is held overwrites all three words.
- R12: A cycle with no check presented changes no output, and access-ok stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A permission-check result is presented this cycle |
| chk_code | input | 2 | Check result: 0 allowed, 1 page not present, 2 user above limit, 3 protected |
| dma_addr | input | 22 | Current DMA address |
| dma_is_read | input | 1 | High when the transfer is a read |
| err_irq_en | input | 1 | Enables the level-7 interrupt on a fault |
| parity_irq_en | input | 1 | Parity-interrupt enable, merged into the status word |
| clr_fault | input | 1 | CPU clear strobe for the captured fault |
| access_ok | output | 1 | One-cycle pulse after an allowed check |
| gen_status | output | 16 | General status word |
| bus_stat_hi | output | 16 | Tag plus upper DMA address bits |
| bus_stat_lo | output | 16 | Lower 16 DMA address bits |
| irq7_req | output | 1 | Level-7 interrupt request |

## Verification
The bench runs every fault code against every combination of the direction bit and the parity enable. A design that dropped one of these merges, or placed it in the wrong bit, would report a general status word one bit away from the expected value. Addresses at both ends of the 22-bit range are used to catch a high bus-status word that is shifted or truncated.

A clear strobe that lands in the same cycle as a fault is exercised. A design that gave the clear priority would read zeros where a fresh fault belongs. An allowed check made while a fault is held is also exercised, to catch a design that wipes or reloads the captured words on a grant. Finally, a disabled fault is made after an enabled one, to show that a disabled fault neither drops an interrupt that is already set nor raises one on its own.

// File: rtl/dma_fault_pkg.sv
`timescale 1ns/1ps
package dma_fault_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        PERM_ALLOW     = 2'd0,
        PERM_PAGE_MISS = 2'd1,
        PERM_USER_HIGH = 2'd2,
        PERM_PROTECT   = 2'd3
    } perm_code_e;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_HELD  = 1'b1
    } hold_state_e;

    localparam logic [WORD_W-1:0] GS_PAGE_MISS = 16'hABFF;
    localparam logic [WORD_W-1:0] GS_USER_HIGH = 16'hBAFF;
    localparam logic [WORD_W-1:0] GS_PROTECT   = 16'hBBFF;
    localparam logic [WORD_W-1:0] GS_READ_BIT  = 16'h4000;
    localparam logic [WORD_W-1:0] GS_PARITY_BIT = 16'h0400;
    localparam logic [WORD_W-1:0] BS_HI_TAG    = 16'h3C00;

    typedef struct packed {
        logic [WORD_W-1:0] gen;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } fault_words_t;

endpackage

// File: rtl/dmaf_classify.sv
`timescale 1ns/1ps
module dmaf_classify
    import dma_fault_pkg::*;
(
    input  logic                chk_valid,
    input  logic [1:0]          chk_code,
    output logic                is_allow,
    output logic                is_fault,
    output logic [WORD_W-1:0]   base_word
);
    perm_code_e code_e;

    always_comb begin
        code_e    = perm_code_e'(chk_code);
        is_allow  = 1'b0;
        is_fault  = 1'b0;
        base_word = '0;
        if (chk_valid) begin
            unique case (code_e)
                PERM_ALLOW: begin
                    is_allow = 1'b1;
                end
                PERM_PAGE_MISS: begin
                    is_fault  = 1'b1;
                    base_word = GS_PAGE_MISS;
                end
                PERM_USER_HIGH: begin
                    is_fault  = 1'b1;
                    base_word = GS_USER_HIGH;
                end
                PERM_PROTECT: begin
                    is_fault  = 1'b1;
                    base_word = GS_PROTECT;
                end
            endcase
        end
    end
endmodule

// File: rtl/dmaf_compose.sv
`timescale 1ns/1ps
module dmaf_compose
    import dma_fault_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [WORD_W-1:0] base_word,
    input  logic              is_read,
    input  logic              parity_en,
    input  logic [ADDR_W-1:0] addr,
    output fault_words_t      words
);
    localparam int HI_BITS = (ADDR_W > WORD_W) ? (ADDR_W - WORD_W) : 0;

    logic [WORD_W-1:0] hi_addr;
    logic [WORD_W-1:0] lo_addr;

    generate
        if (HI_BITS > 0) begin : g_split
            assign hi_addr = {{(WORD_W-HI_BITS){1'b0}}, addr[ADDR_W-1:WORD_W]};
            assign lo_addr = addr[WORD_W-1:0];
        end else if (ADDR_W == WORD_W) begin : g_exact
            assign hi_addr = '0;
            assign lo_addr = addr;
        end else begin : g_narrow
            assign hi_addr = '0;
            assign lo_addr = {{(WORD_W-ADDR_W){1'b0}}, addr};
        end
    endgenerate

    always_comb begin
        words.gen = base_word;
        if (is_read)   words.gen = words.gen | GS_READ_BIT;
        if (parity_en) words.gen = words.gen | GS_PARITY_BIT;
        words.hi = BS_HI_TAG | hi_addr;
        words.lo = lo_addr;
    end
endmodule

// File: rtl/dmaf_ctrl.sv
`timescale 1ns/1ps
module dmaf_ctrl
    import dma_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_now,
    input  logic clr_req,
    output logic load_en,
    output logic wipe_en
);
    hold_state_e state_q;
    hold_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        wipe_en = 1'b0;
        unique case (state_q)
            ST_CLEAN: begin
                if (fault_now) begin
                    load_en = 1'b1;
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (fault_now) begin
                    load_en = 1'b1;
                    state_d = ST_HELD;
                end else if (clr_req) begin
                    wipe_en = 1'b1;
                    state_d = ST_CLEAN;
                end
            end
        endcase
    end
endmodule

// File: rtl/dma_fault_capture.sv
`timescale 1ns/1ps
module dma_fault_capture
    import dma_fault_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [1:0]        chk_code,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_is_read,
    input  logic              err_irq_en,
    input  logic              parity_irq_en,
    input  logic              clr_fault,
    output logic              access_ok,
    output logic [15:0]       gen_status,
    output logic [15:0]       bus_stat_hi,
    output logic [15:0]       bus_stat_lo,
    output logic              irq7_req
);
    logic              is_allow;
    logic              is_fault;
    logic [WORD_W-1:0] base_word;
    fault_words_t      words;
    logic              load_en;
    logic              wipe_en;

    dmaf_classify u_classify (
        .chk_valid (chk_valid),
        .chk_code  (chk_code),
        .is_allow  (is_allow),
        .is_fault  (is_fault),
        .base_word (base_word)
    );

    dmaf_compose #(.ADDR_W(ADDR_W)) u_compose (
        .base_word (base_word),
        .is_read   (dma_is_read),
        .parity_en (parity_irq_en),
        .addr      (dma_addr),
        .words     (words)
    );

    dmaf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_now (is_fault),
        .clr_req   (clr_fault),
        .load_en   (load_en),
        .wipe_en   (wipe_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            access_ok   <= 1'b0;
            gen_status  <= '0;
            bus_stat_hi <= '0;
            bus_stat_lo <= '0;
            irq7_req    <= 1'b0;
        end else begin
            access_ok <= is_allow;
            if (load_en) begin
                gen_status  <= words.gen;
                bus_stat_hi <= words.hi;
                bus_stat_lo <= words.lo;
                irq7_req    <= (irq7_req & ~clr_fault) | err_irq_en;
            end else if (wipe_en) begin
                gen_status  <= '0;
                bus_stat_hi <= '0;
                bus_stat_lo <= '0;
                irq7_req    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_fault_capture_chk.sv
`timescale 1ns/1ps
module dma_fault_capture_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_valid,
    input logic [1:0]        chk_code,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_is_read,
    input logic              err_irq_en,
    input logic              parity_irq_en,
    input logic              clr_fault,
    input logic              access_ok,
    input logic [15:0]       gen_status,
    input logic [15:0]       bus_stat_hi,
    input logic [15:0]       bus_stat_lo,
    input logic              irq7_req
);
    logic denied;
    logic granted;
    assign denied  = chk_valid && (chk_code != 2'd0);
    assign granted = chk_valid && (chk_code == 2'd0);

    a_r2_ok_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        granted |=> access_ok);

    a_r2_words_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && !clr_fault) |=> ($stable(gen_status) && $stable(bus_stat_lo) && $stable(irq7_req)));

    a_r6_read_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (denied && dma_is_read) |=> gen_status[14]);

    a_r7_parity_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (denied && parity_irq_en) |=> gen_status[10]);

    a_r8_low_addr: assert property (@(posedge clk) disable iff (!rst_n)
        denied |=> (bus_stat_lo == $past(dma_addr[15:0])));

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq7_req) |-> $past(denied && err_irq_en));

    a_r10_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fault && !denied) |=> (gen_status == 16'h0000 && !irq7_req));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_valid && !clr_fault) |=> (!access_ok && $stable(gen_status) && $stable(bus_stat_hi)));
endmodule

bind dma_fault_capture dma_fault_capture_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .chk_valid     (chk_valid),
    .chk_code      (chk_code),
    .dma_addr      (dma_addr),
    .dma_is_read   (dma_is_read),
    .err_irq_en    (err_irq_en),
    .parity_irq_en (parity_irq_en),
    .clr_fault     (clr_fault),
    .access_ok     (access_ok),
    .gen_status    (gen_status),
    .bus_stat_hi   (bus_stat_hi),
    .bus_stat_lo   (bus_stat_lo),
    .irq7_req      (irq7_req)
);

// File: tb/dma_fault_capture_tb_top.sv
`timescale 1ns/1ps
module dma_fault_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0;
    logic [1:0]  chk_code = 2'd0;
    logic [21:0] dma_addr = '0;
    logic        dma_is_read = 1'b0;
    logic        err_irq_en = 1'b0;
    logic        parity_irq_en = 1'b0;
    logic        clr_fault = 1'b0;
    logic        access_ok;
    logic [15:0] gen_status;
    logic [15:0] bus_stat_hi;
    logic [15:0] bus_stat_lo;
    logic        irq7_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit started = 0;
    string cur_tag = "R1";
    string tag_q = "R1";

    int m_ok = 0;
    int m_gen = 0;
    int m_hi = 0;
    int m_lo = 0;
    int m_irq = 0;

    always #10 clk = ~clk;

    dma_fault_capture dut_i (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_code(chk_code),
        .dma_addr(dma_addr), .dma_is_read(dma_is_read), .err_irq_en(err_irq_en),
        .parity_irq_en(parity_irq_en), .clr_fault(clr_fault), .access_ok(access_ok),
        .gen_status(gen_status), .bus_stat_hi(bus_stat_hi), .bus_stat_lo(bus_stat_lo),
        .irq7_req(irq7_req)
    );

    // Behavioural reference: next-cycle values from the requirements
    always @(posedge clk) begin
        started <= 1;
        tag_q   <= cur_tag;
        if (!rst_n) begin
            m_ok = 0; m_gen = 0; m_hi = 0; m_lo = 0; m_irq = 0;
        end else begin
            m_ok = (chk_valid && chk_code == 0) ? 1 : 0;
            if (chk_valid && chk_code != 0) begin
                if (chk_code == 1)      m_gen = 'hABFF;
                else if (chk_code == 2) m_gen = 'hBAFF;
                else                    m_gen = 'hBBFF;
                if (dma_is_read)   m_gen = m_gen + 'h4000;
                if (parity_irq_en) m_gen = m_gen + 'h0400;
                m_hi = 'h3C00 + int'(dma_addr) / 65536;
                m_lo = int'(dma_addr) % 65536;
                m_irq = ((clr_fault ? 0 : m_irq) || err_irq_en) ? 1 : 0;
            end else if (clr_fault) begin
                m_gen = 0; m_hi = 0; m_lo = 0; m_irq = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            checks++;
            if (int'(access_ok) != m_ok || int'(gen_status) != m_gen ||
                int'(bus_stat_hi) != m_hi || int'(bus_stat_lo) != m_lo ||
                int'(irq7_req) != m_irq) begin
                errors++;
                $display("FAIL %s: ok=%0d gen=%h hi=%h lo=%h irq=%0d, expected ok=%0d gen=%h hi=%h lo=%h irq=%0d",
                         tag_q, access_ok, gen_status, bus_stat_hi, bus_stat_lo, irq7_req,
                         m_ok, m_gen[15:0], m_hi[15:0], m_lo[15:0], m_irq);
            end
        end
    end

    task automatic step(input bit v, input logic [1:0] c, input logic [21:0] a,
                        input bit rd, input bit eie, input bit pie, input bit clr,
                        input string tag);
        @(negedge clk);
        #1;
        chk_valid = v; chk_code = c; dma_addr = a; dma_is_read = rd;
        err_irq_en = eie; parity_irq_en = pie; clr_fault = clr; cur_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        step(0, 0, 22'h000000, 0, 0, 0, 0, "R1");
        step(0, 0, 22'h123456, 1, 1, 1, 0, "R12");
        step(1, 0, 22'h2ABCDE, 1, 1, 1, 0, "R2");
        step(1, 1, 22'h1F1234, 0, 0, 0, 0, "R3");
        step(0, 2, 22'h000000, 1, 1, 1, 0, "R12");
        step(0, 0, 22'h000000, 0, 0, 0, 1, "R10");
        step(1, 2, 22'h3FFFFF, 0, 0, 0, 0, "R4");
        step(1, 3, 22'h000000, 0, 0, 0, 0, "R5");
        step(1, 3, 22'h200001, 1, 0, 0, 0, "R6");
        step(1, 1, 22'h0A5A5A, 0, 0, 1, 0, "R7");
        step(1, 2, 22'h3FFFFF, 1, 0, 1, 0, "R8");
        step(1, 3, 22'h010000, 1, 1, 1, 0, "R9");
        step(1, 0, 22'h155555, 0, 0, 0, 0, "R2");
        step(1, 1, 22'h2C0FFE, 0, 0, 0, 0, "R11");
        step(0, 0, 22'h000000, 0, 0, 0, 0, "R9");
        step(1, 2, 22'h001234, 1, 0, 0, 1, "R10");
        step(1, 1, 22'h004321, 0, 1, 0, 1, "R10");
        step(0, 0, 22'h000000, 0, 0, 0, 1, "R10");
        step(1, 1, 22'h3C0000, 0, 0, 0, 0, "R9");
        step(1, 0, 22'h000001, 0, 0, 0, 1, "R10");
        for (int c = 1; c < 4; c++)
            for (int k = 0; k < 4; k++)
                step(1, c[1:0], 22'(c * 22'h0F0F1 + k), k[0], 0, k[1], 0, "R6");
        step(0, 0, 22'h000000, 0, 0, 0, 0, "R12");
        step(0, 0, 22'h000000, 0, 0, 0, 0, "R12");
        @(negedge clk);
        #2;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule